// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block fronts an on-chip scratchpad made of sixteen single-ported banks. Each bank is one 32-bit word wide. A request carries sixteen lanes, and each lane has an enable, a word address and, for stores, a data word. The block maps each lane to a bank using the low bits of its word address. When two or more active lanes land in the same bank, the block spreads those accesses over several cycles, one access per bank per cycle. When every active lane names the same word, the block serves them all together in a single broadcast cycle.

A request is taken when the block is idle, and `busy` then stays high while the banks are worked through. Completion is marked by a one-cycle `done` pulse. At that pulse the block reports how many service cycles were spent, and that count can be checked against the conflict degree predicted for the access pattern. Loads return their words per lane, together with a per-lane valid mask. Stores go through the same arbitration, so the lane order inside a bank decides which store wins.

Top module: `bank_conflict_serializer`

## Requirements
- R1: The bank of a lane is the low four bits of its word address. When every active lane sits in a different bank, the request takes exactly one service cycle.
- R2: When all active lanes carry the same word address, the request takes one service cycle. Every active lane then receives that word (broadcast).
- R3: In every other case, `cycles` reported with `done` equals the largest number of active lanes mapped to any one bank. It always lies between 1 and 16.
- R4: Lanes that share a word count as separate accesses unless the whole request is a broadcast. Four lanes per word, as with consecutive byte elements, costs 4 cycles. Two lanes per word, as with consecutive 16-bit elements, costs 2 cycles.
- R5: With sixteen lanes at word stride s, any odd s costs one cycle. Strides 2, 4, 8 and 16 cost 2, 4, 8 and 16 cycles.
- R6: Inactive lanes are ignored and add no cost. At `done`, `rsp_valid` equals the set of active lanes of the request. This holds for loads and stores alike. An inactive lane's `rsp_rdata` slice is zero, and a store lane's slice is also zero. A request with no active lane still takes one cycle.
- R7: Within one bank, lanes are served in ascending lane order, one per cycle. When several stores hit the same word, the highest-numbered active lane's data is what remains. This holds both when the stores are serialized and when they are broadcast.
- R8: A request is accepted on a clock edge where `req_valid` is high and `busy` is low. `busy` then stays high for exactly `cycles` clock cycles. `done` is high for one cycle, right after `busy` falls. A `req_valid` raised while `busy` is high has no effect.
- R9: While reset is asserted and right after it, `busy` and `done` are low, `rsp_valid` is zero and `cycles` is zero.
- R10: For a load, active lane l returns the word last stored at its address in `rsp_rdata[32*l +: 32]`. The response stays stable until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered; taken when not busy |
| req_write | input | 1 | 1 = store request, 0 = load request |
| req_lane_en | input | 16 | Per-lane active flags |
| req_addr | input | 160 | Word address per lane, lane l at bits 10*l +: 10 |
| req_wdata | input | 512 | Store data per lane, lane l at bits 32*l +: 32 |
| busy | output | 1 | Request in service |
| done | output | 1 | One-cycle completion pulse |
| cycles | output | 5 | Service cycles spent by the last request |
| rsp_valid | output | 16 | Lanes served by the last request |
| rsp_rdata | output | 512 | Load data per lane, lane l at bits 32*l +: 32 |

## Verification
The hardest situation to reach is the lane order inside one bank. For loads the order cannot be seen, because every lane gets the same word whatever the order. So the stimulus places stores from three lanes on one word, and adds a fourth active lane on another word so that the request is not a broadcast. It then reads the word back and checks that the highest lane's data survived. It also checks that the cost was three cycles. The same store without the extra lane exercises the broadcast path and should leave the same survivor. A request raised in the middle of a sixteen-cycle load is then shown to have no effect, by reading back the word it would have overwritten.

// File: rtl/bank_xbar_pkg.sv
package bank_xbar_pkg;

   typedef enum logic {
      PH_IDLE  = 1'b0,
      PH_SERVE = 1'b1
   } phase_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/bank_lane_map.sv
module bank_lane_map #(
   parameter int LANES    = 16,
   parameter int ADDR_W   = 10,
   parameter int BANKS    = 16,
   parameter bit BCAST_EN = 1'b1
) (
   input  logic [LANES-1:0]             lane_en,
   input  logic [LANES*ADDR_W-1:0]      lane_addr,
   output logic [LANES*$clog2(BANKS)-1:0] lane_bank,
   output logic                         all_same
);
   localparam int BANK_W = $clog2(BANKS);

   genvar l;
   generate
      for (l = 0; l < LANES; l++) begin : g_bank
         assign lane_bank[l*BANK_W +: BANK_W] = lane_addr[l*ADDR_W +: BANK_W];
      end

      if (BCAST_EN) begin : g_bcast
         logic [ADDR_W-1:0] ref_addr;
         logic [LANES-1:0]  hit;

         always_comb begin
            ref_addr = '0;
            for (int k = LANES - 1; k >= 0; k--) begin
               if (lane_en[k]) ref_addr = lane_addr[k*ADDR_W +: ADDR_W];
            end
         end

         for (l = 0; l < LANES; l++) begin : g_hit
            assign hit[l] = !lane_en[l] || (lane_addr[l*ADDR_W +: ADDR_W] == ref_addr);
         end

         assign all_same = &hit;
      end else begin : g_no_bcast
         assign all_same = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/bank_grant_arb.sv
module bank_grant_arb #(
   parameter int LANES = 16,
   parameter int BANKS = 16
) (
   input  logic [LANES-1:0]                          pend,
   input  logic [LANES*$clog2(BANKS)-1:0]            lane_bank,
   input  logic                                      bcast,
   output logic [LANES-1:0]                          grant,
   output logic [BANKS-1:0]                          bank_act,
   output logic [BANKS*bank_xbar_pkg::idx_width(LANES)-1:0] bank_lane
);
   localparam int BANK_W = $clog2(BANKS);
   localparam int LIDX_W = bank_xbar_pkg::idx_width(LANES);

   genvar l, b;
   generate
      for (l = 0; l < LANES; l++) begin : g_lane
         logic blocked;
         always_comb begin
            blocked = 1'b0;
            for (int k = 0; k < l; k++) begin
               if (pend[k] && (lane_bank[k*BANK_W +: BANK_W] == lane_bank[l*BANK_W +: BANK_W]))
                  blocked = 1'b1;
            end
         end
         assign grant[l] = pend[l] && (bcast || !blocked);
      end

      for (b = 0; b < BANKS; b++) begin : g_bank
         logic [LIDX_W-1:0] lo_sel;
         logic [LIDX_W-1:0] hi_sel;
         logic              any;
         always_comb begin
            lo_sel = '0;
            hi_sel = '0;
            any    = 1'b0;
            for (int k = LANES - 1; k >= 0; k--) begin
               if (pend[k] && (lane_bank[k*BANK_W +: BANK_W] == BANK_W'(b))) lo_sel = LIDX_W'(k);
            end
            for (int k = 0; k < LANES; k++) begin
               if (pend[k] && (lane_bank[k*BANK_W +: BANK_W] == BANK_W'(b))) begin
                  hi_sel = LIDX_W'(k);
                  any    = 1'b1;
               end
            end
         end
         assign bank_act[b]                     = any;
         assign bank_lane[b*LIDX_W +: LIDX_W]   = bcast ? hi_sel : lo_sel;
      end
   endgenerate

endmodule

// File: rtl/scratch_banks.sv
module scratch_banks #(
   parameter int BANKS  = 16,
   parameter int ROW_W  = 6,
   parameter int DATA_W = 32
) (
   input  logic                      clk,
   input  logic [BANKS-1:0]          bk_we,
   input  logic [BANKS*ROW_W-1:0]    bk_row,
   input  logic [BANKS*DATA_W-1:0]   bk_wdata,
   output logic [BANKS*DATA_W-1:0]   bk_rdata
);
   localparam int ROWS = 1 << ROW_W;

   genvar b;
   generate
      for (b = 0; b < BANKS; b++) begin : g_bank
         logic [DATA_W-1:0] mem [ROWS];
         logic [ROW_W-1:0]  row;

         assign row = bk_row[b*ROW_W +: ROW_W];

         always_ff @(posedge clk) begin
            if (bk_we[b]) mem[row] <= bk_wdata[b*DATA_W +: DATA_W];
         end

         assign bk_rdata[b*DATA_W +: DATA_W] = mem[row];
      end
   endgenerate

endmodule

// File: rtl/bank_conflict_serializer.sv
module bank_conflict_serializer
   import bank_xbar_pkg::*;
#(
   parameter int LANES    = 16,
   parameter int BANKS    = 16,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 10,
   parameter bit BCAST_EN = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   input  logic                        req_write,
   input  logic [LANES-1:0]            req_lane_en,
   input  logic [LANES*ADDR_W-1:0]     req_addr,
   input  logic [LANES*DATA_W-1:0]     req_wdata,
   output logic                        busy,
   output logic                        done,
   output logic [$clog2(LANES+1)-1:0]  cycles,
   output logic [LANES-1:0]            rsp_valid,
   output logic [LANES*DATA_W-1:0]     rsp_rdata
);
   localparam int BANK_W = $clog2(BANKS);
   localparam int ROW_W  = ADDR_W - BANK_W;
   localparam int CNT_W  = $clog2(LANES + 1);
   localparam int LIDX_W = idx_width(LANES);

   generate
      if (BANKS < 2 || (BANKS & (BANKS - 1)) != 0) begin : g_chk_banks
         $error("BANKS must be a power of two of at least 2");
      end
      if (ADDR_W <= BANK_W) begin : g_chk_addr
         $error("ADDR_W must exceed the bank index width");
      end
      if (LANES < 2) begin : g_chk_lanes
         $error("LANES must be at least 2");
      end
      if (DATA_W < 1) begin : g_chk_data
         $error("DATA_W must be positive");
      end
   endgenerate

   // request state
   phase_e                     phase_q;
   logic [LANES-1:0]           pend_q;
   logic [ADDR_W-1:0]          addr_q  [LANES];
   logic [DATA_W-1:0]          wdata_q [LANES];
   logic [LANES*BANK_W-1:0]    bank_q;
   logic                       wr_q;
   logic                       bcast_q;
   logic [CNT_W-1:0]           cnt_q;
   logic [CNT_W-1:0]           cycles_q;
   logic                       done_q;
   logic [LANES-1:0]           rvld_q;
   logic [DATA_W-1:0]          rdat_q  [LANES];

   // incoming lane mapping
   logic [LANES*BANK_W-1:0]    in_bank;
   logic                       in_same;

   bank_lane_map #(
      .LANES    (LANES),
      .ADDR_W   (ADDR_W),
      .BANKS    (BANKS),
      .BCAST_EN (BCAST_EN)
   ) u_map (
      .lane_en   (req_lane_en),
      .lane_addr (req_addr),
      .lane_bank (in_bank),
      .all_same  (in_same)
   );

   // per-cycle arbitration over pending lanes
   logic [LANES-1:0]           grant;
   logic [BANKS-1:0]           bank_act;
   logic [BANKS*LIDX_W-1:0]    bank_lane;

   bank_grant_arb #(
      .LANES (LANES),
      .BANKS (BANKS)
   ) u_arb (
      .pend      (pend_q),
      .lane_bank (bank_q),
      .bcast     (bcast_q),
      .grant     (grant),
      .bank_act  (bank_act),
      .bank_lane (bank_lane)
   );

   // bank port steering
   logic [BANKS-1:0]           bk_we;
   logic [BANKS*ROW_W-1:0]     bk_row;
   logic [BANKS*DATA_W-1:0]    bk_wdata;
   logic [BANKS*DATA_W-1:0]    bk_rdata;

   always_comb begin
      for (int b = 0; b < BANKS; b++) begin
         logic [LIDX_W-1:0] sel;
         sel = bank_lane[b*LIDX_W +: LIDX_W];
         bk_row[b*ROW_W +: ROW_W]     = addr_q[sel][ADDR_W-1:BANK_W];
         bk_wdata[b*DATA_W +: DATA_W] = wdata_q[sel];
         bk_we[b]                     = (phase_q == PH_SERVE) && wr_q && bank_act[b];
      end
   end

   scratch_banks #(
      .BANKS  (BANKS),
      .ROW_W  (ROW_W),
      .DATA_W (DATA_W)
   ) u_banks (
      .clk      (clk),
      .bk_we    (bk_we),
      .bk_row   (bk_row),
      .bk_wdata (bk_wdata),
      .bk_rdata (bk_rdata)
   );

   // return path: each lane looks at its own bank
   logic [DATA_W-1:0]          lane_rd [LANES];
   always_comb begin
      for (int l = 0; l < LANES; l++) begin
         lane_rd[l] = bk_rdata[bank_q[l*BANK_W +: BANK_W]*DATA_W +: DATA_W];
      end
   end

   logic [LANES-1:0]           pend_left;
   assign pend_left = pend_q & ~grant;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         pend_q   <= '0;
         bank_q   <= '0;
         wr_q     <= 1'b0;
         bcast_q  <= 1'b0;
         cnt_q    <= '0;
         cycles_q <= '0;
         done_q   <= 1'b0;
         rvld_q   <= '0;
         for (int l = 0; l < LANES; l++) begin
            addr_q[l]  <= '0;
            wdata_q[l] <= '0;
            rdat_q[l]  <= '0;
         end
      end else begin
         done_q <= 1'b0;
         if (phase_q == PH_IDLE) begin
            if (req_valid) begin
               phase_q <= PH_SERVE;
               pend_q  <= req_lane_en;
               bank_q  <= in_bank;
               wr_q    <= req_write;
               bcast_q <= in_same;
               cnt_q   <= '0;
               rvld_q  <= '0;
               for (int l = 0; l < LANES; l++) begin
                  addr_q[l]  <= req_addr[l*ADDR_W +: ADDR_W];
                  wdata_q[l] <= req_wdata[l*DATA_W +: DATA_W];
                  rdat_q[l]  <= '0;
               end
            end
         end else begin
            cnt_q  <= cnt_q + 1'b1;
            pend_q <= pend_left;
            for (int l = 0; l < LANES; l++) begin
               if (grant[l]) begin
                  rvld_q[l] <= 1'b1;
                  if (!wr_q) rdat_q[l] <= lane_rd[l];
               end
            end
            if (pend_left == '0) begin
               phase_q  <= PH_IDLE;
               done_q   <= 1'b1;
               cycles_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign busy      = (phase_q == PH_SERVE);
   assign done      = done_q;
   assign cycles    = cycles_q;
   assign rsp_valid = rvld_q;

   genvar g;
   generate
      for (g = 0; g < LANES; g++) begin : g_rsp
         assign rsp_rdata[g*DATA_W +: DATA_W] = rdat_q[g];
      end
   endgenerate

endmodule

// File: rtl/bank_conflict_serializer_chk.sv
module bank_conflict_serializer_chk #(
   parameter int LANES = 16,
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [LANES-1:0] req_lane_en,
   input logic             busy,
   input logic             done,
   input logic [CNT_W-1:0] cycles,
   input logic [LANES-1:0] rsp_valid
);
   logic [LANES-1:0] act_q;
   logic [CNT_W:0]   bcnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= '0;
         bcnt_q <= '0;
      end else if (req_valid && !busy) begin
         act_q  <= req_lane_en;
         bcnt_q <= '0;
      end else if (busy) begin
         bcnt_q <= bcnt_q + 1'b1;
      end
   end

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   assert_busy_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ({1'b0, cycles} == bcnt_q));

   assert_cycle_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cycles != '0 && cycles <= CNT_W'(LANES)));

   assert_valid_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rsp_valid == act_q));

endmodule

bind bank_conflict_serializer bank_conflict_serializer_chk #(
   .LANES (LANES),
   .CNT_W ($clog2(LANES + 1))
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_lane_en (req_lane_en),
   .busy        (busy),
   .done        (done),
   .cycles      (cycles),
   .rsp_valid   (rsp_valid)
);

// File: tb/bank_conflict_serializer_test.sv
module bank_conflict_serializer_test;
   localparam int CLK_PERIOD = 10;
   localparam int LANES  = 16;
   localparam int ADDR_W = 10;
   localparam int DATA_W = 32;
   localparam int CNT_W  = 5;
   localparam int WORDS  = 1 << ADDR_W;
   localparam int NVEC   = 14;

   // base, stride, lanes per word divisor, lane mask, expected cycles, requirement
   localparam int VEC [NVEC][6] = '{
      '{  0,  1, 1, 16'hFFFF,  1, 1},  // R1 unit stride
      '{  5,  3, 1, 16'hFFFF,  1, 5},  // R5 odd stride
      '{  0,  2, 1, 16'hFFFF,  2, 5},  // R5 stride 2
      '{  0,  8, 1, 16'hFFFF,  8, 5},  // R5 stride 8
      '{  0, 16, 1, 16'hFFFF, 16, 5},  // R5 stride 16
      '{ 77,  0, 1, 16'hFFFF,  1, 2},  // R2 full broadcast
      '{200,  1, 4, 16'hFFFF,  4, 4},  // R4 byte elements
      '{300,  1, 2, 16'hFFFF,  2, 4},  // R4 halfword elements
      '{100,  7, 1, 16'hFFFF,  1, 5},  // R5 stride 7
      '{  0,  2, 1, 16'h00FF,  1, 6},  // R6 upper lanes off
      '{  0, 16, 1, 16'h000F,  4, 6},  // R6 partial same-bank
      '{  9,  0, 1, 16'h0000,  1, 6},  // R6 empty request
      '{  1,  4, 1, 16'hFFFF,  4, 3},  // R3 four banks loaded
      '{ 50,  0, 1, 16'h8421,  1, 2}   // R2 sparse broadcast
   };

   logic                      clk;
   logic                      rst_n;
   logic                      req_valid;
   logic                      req_write;
   logic [LANES-1:0]          req_lane_en;
   logic [LANES*ADDR_W-1:0]   req_addr;
   logic [LANES*DATA_W-1:0]   req_wdata;
   logic                      busy;
   logic                      done;
   logic [CNT_W-1:0]          cycles;
   logic [LANES-1:0]          rsp_valid;
   logic [LANES*DATA_W-1:0]   rsp_rdata;

   bank_conflict_serializer uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .req_lane_en (req_lane_en),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .busy        (busy),
      .done        (done),
      .cycles      (cycles),
      .rsp_valid   (rsp_valid),
      .rsp_rdata   (rsp_rdata)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   int                 n_tests;
   int                 n_fail;
   logic [DATA_W-1:0]  shadow [WORDS];
   logic [ADDR_W-1:0]  ta [LANES];
   logic [DATA_W-1:0]  td [LANES];
   int                 ob_busy;

   function automatic logic [DATA_W-1:0] init_word(input int a);
      return 32'hC0DE_0000 + 32'(a * 17);
   endfunction

   task automatic chk(input bit ok, input string tag, input string msg);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s", tag, msg);
      end
   endtask

   task automatic drive_req(input bit wr, input logic [LANES-1:0] en);
      @(negedge clk);
      req_valid   = 1'b1;
      req_write   = wr;
      req_lane_en = en;
      for (int l = 0; l < LANES; l++) begin
         req_addr[l*ADDR_W +: ADDR_W]  = ta[l];
         req_wdata[l*DATA_W +: DATA_W] = td[l];
      end
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_done();
      ob_busy = 0;
      for (int i = 0; i < 200; i++) begin
         if (done) break;
         if (busy) ob_busy++;
         @(negedge clk);
      end
      if (!done) chk(1'b0, "R8", "done never rose: actual 0 expected 1");
   endtask

   task automatic shadow_store(input logic [LANES-1:0] en);
      for (int l = 0; l < LANES; l++) begin
         if (en[l]) shadow[ta[l]] = td[l];
      end
   endtask

   task automatic expect_read(input logic [LANES-1:0] en, input string tag);
      logic [LANES*DATA_W-1:0] exp_d;
      exp_d = '0;
      for (int l = 0; l < LANES; l++) begin
         if (en[l]) exp_d[l*DATA_W +: DATA_W] = shadow[ta[l]];
      end
      chk(rsp_valid == en, tag,
          $sformatf("valid mask actual %h expected %h", rsp_valid, en));
      chk(rsp_rdata == exp_d, tag,
          $sformatf("read data actual %h expected %h", rsp_rdata, exp_d));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL R8 watchdog: actual still running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int max_cyc;
      n_tests     = 0;
      n_fail      = 0;
      rst_n       = 1'b0;
      req_valid   = 1'b0;
      req_write   = 1'b0;
      req_lane_en = '0;
      req_addr    = '0;
      req_wdata   = '0;
      for (int a = 0; a < WORDS; a++) shadow[a] = 'x;

      // R9 reset state
      repeat (3) @(negedge clk);
      chk(!busy && !done && rsp_valid == '0 && cycles == '0, "R9",
          $sformatf("in reset actual busy=%b done=%b vld=%h cyc=%0d expected 0", busy, done, rsp_valid, cycles));
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && rsp_valid == '0 && cycles == '0, "R9",
          $sformatf("after reset actual busy=%b done=%b vld=%h cyc=%0d expected 0", busy, done, rsp_valid, cycles));

      // fill the whole scratchpad with unit-stride stores
      max_cyc = 0;
      for (int blk = 0; blk < WORDS / LANES; blk++) begin
         for (int l = 0; l < LANES; l++) begin
            ta[l] = ADDR_W'(blk * LANES + l);
            td[l] = init_word(blk * LANES + l);
         end
         drive_req(1'b1, '1);
         wait_done();
         if (int'(cycles) > max_cyc) max_cyc = int'(cycles);
         shadow_store('1);
      end
      chk(max_cyc == 1, "R1", $sformatf("fill cycles actual %0d expected 1", max_cyc));

      // table-driven loads
      for (int v = 0; v < NVEC; v++) begin
         logic [LANES-1:0] en;
         string tag;
         en  = LANES'(VEC[v][3]);
         tag = $sformatf("R%0d", VEC[v][5]);
         for (int l = 0; l < LANES; l++) begin
            ta[l] = ADDR_W'(VEC[v][0] + (VEC[v][1] * l) / VEC[v][2]);
            td[l] = '0;
         end
         drive_req(1'b0, en);
         wait_done();
         chk(int'(cycles) == VEC[v][4], tag,
             $sformatf("vector %0d cycles actual %0d expected %0d", v, cycles, VEC[v][4]));
         expect_read(en, (v == 0) ? "R10" : tag);
      end

      // R8 busy lasts exactly the reported cycles; done is one cycle wide
      for (int l = 0; l < LANES; l++) ta[l] = ADDR_W'(8 * l);
      drive_req(1'b0, '1);
      wait_done();
      chk(ob_busy == 8, "R8", $sformatf("busy cycles actual %0d expected 8", ob_busy));
      @(negedge clk);
      chk(!done && !busy, "R8", $sformatf("after pulse actual done=%b busy=%b expected 0 0", done, busy));

      // R7 serialized store conflict: lanes 2,6,11 on one word, lane 3 elsewhere
      for (int l = 0; l < LANES; l++) begin
         ta[l] = 10'd300;
         td[l] = 32'h1000_0000 + 32'(l);
      end
      ta[3] = 10'd301;
      drive_req(1'b1, 16'h0844 | 16'h0008);
      wait_done();
      chk(cycles == 5'd3, "R7", $sformatf("store conflict cycles actual %0d expected 3", cycles));
      chk(rsp_valid == 16'h084C && rsp_rdata == '0, "R6",
          $sformatf("store response actual vld=%h expected 084c with zero data", rsp_valid));
      shadow_store(16'h084C);
      ta[0] = 10'd300;
      ta[1] = 10'd301;
      drive_req(1'b0, 16'h0003);
      wait_done();
      chk(rsp_rdata[31:0] == 32'h1000_000B, "R7",
          $sformatf("survivor actual %h expected 1000000b", rsp_rdata[31:0]));
      expect_read(16'h0003, "R7");

      // R7 broadcast store: lanes 0,5,9 on one word
      for (int l = 0; l < LANES; l++) begin
         ta[l] = 10'd400;
         td[l] = 32'h2000_0000 + 32'(l);
      end
      drive_req(1'b1, 16'h0221);
      wait_done();
      chk(cycles == 5'd1, "R2", $sformatf("broadcast store cycles actual %0d expected 1", cycles));
      shadow_store(16'h0221);
      drive_req(1'b0, 16'h0001);
      wait_done();
      chk(rsp_rdata[31:0] == 32'h2000_0009, "R7",
          $sformatf("broadcast survivor actual %h expected 20000009", rsp_rdata[31:0]));

      // R8 a request raised while busy is dropped
      for (int l = 0; l < LANES; l++) ta[l] = ADDR_W'(16 * l);
      drive_req(1'b0, '1);
      @(negedge clk);
      req_valid   = 1'b1;
      req_write   = 1'b1;
      req_lane_en = '1;
      for (int l = 0; l < LANES; l++) begin
         req_addr[l*ADDR_W +: ADDR_W]  = 10'd500;
         req_wdata[l*DATA_W +: DATA_W] = 32'hDEAD_BEEF;
      end
      @(negedge clk);
      req_valid = 1'b0;
      wait_done();
      chk(cycles == 5'd16, "R5", $sformatf("stride 16 cycles actual %0d expected 16", cycles));
      ta[0] = 10'd500;
      drive_req(1'b0, 16'h0001);
      wait_done();
      chk(rsp_rdata[31:0] == shadow[500], "R8",
          $sformatf("word after ignored store actual %h expected %h", rsp_rdata[31:0], shadow[500]));

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule